// File: doc/BRIEF.md
# Carry-Free Binary Signed-Digit Adder

This block adds or subtracts two binary signed-digit numbers whose digits take the values -1, 0 and +1. The operands arrive as pairs of bit vectors, one flag vector marking negative digits and one marking positive digits. The result has one more digit than the operands, and it is captured in a single output register.

Each digit position forms an outgoing transfer digit and a sum digit. Binary signed-digit addition has two ways to split an operand sum of -1 or +1. To pick between them, each position also passes its upper neighbour a one-bit hint. The hint depends only on that position's own operand digits. Because of this, no signal ripples along the word, and every result digit depends on at most three adjacent operand positions.

For subtraction, the negative and positive flags of the second operand are swapped, which negates every digit. No recoding of the inputs is needed. The logic depth is the same at any width.

Top module: `bsd_cf_adder`

## Requirements
- R1: A digit is coded as (negative flag, positive flag): -1 is (1,0), 0 is (0,0) and +1 is (0,1). Operands never carry (1,1), and the result never contains (1,1) at any digit.
- R2: With `sub_i` low, the integer value of the result equals value(A) + value(B), where value sums digit·2^i over the positions.
- R3: With `sub_i` high, the integer value of the result equals value(A) - value(B).
- R4: The result has NDIG+1 digits, and the top digit at index NDIG is the transfer out of the highest position. For example, adding two all-(+1) operands yields a top digit of +1.
- R5: At every position i, x_i + y_i + t_i = 2·t_{i+1} + s_i. Here y is B after the optional negation, t_0 is 0, and the hint into position 0 is 0.
- R6: The hint leaving position i is true exactly when x_i or y_i is -1. It holds the invariant that an outgoing transfer of +1 comes with a false hint and an outgoing transfer of -1 comes with a true hint.
- R7: The result appears on the outputs one clock edge after the operands are applied. While `rst_n` is low at a rising edge, all output flags clear to 0, which is the all-zero digit vector.
- R8: Changing operand digits only at position j can alter only result digits j, j+1 and j+2. All other result digits keep their values.
- R9: Subtracting any operand from itself gives a result in which every digit is (0,0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_i | input | 1 | 1 selects A - B, 0 selects A + B |
| a_neg_i | input | NDIG | Negative flags of operand A |
| a_pos_i | input | NDIG | Positive flags of operand A |
| b_neg_i | input | NDIG | Negative flags of operand B |
| b_pos_i | input | NDIG | Positive flags of operand B |
| sum_neg_o | output | NDIG+1 | Negative flags of the registered result |
| sum_pos_o | output | NDIG+1 | Positive flags of the registered result |

## Verification
The assertions check three things on every cycle, at every position. The first is the local digit balance between the operand digits, the incoming transfer, the outgoing transfer and the sum digit. The second is the invariant between each hint and the transfer beside it. The third is that no illegal (1,1) digit reaches the output.

Some properties can only be shown by the bench's scenarios. The whole-word value being correct needs those scenarios: an exhaustive sweep at four digits and random vectors at eight. So do the top digit being the final transfer, the bounded reach of one operand change, the all-zero result of self-subtraction, and the reset and latency behaviour.

// File: rtl/bsd_pkg.sv
// Shared types for the signed-digit adder.
// A digit is a packed pair: neg in the upper bit, pos in the lower bit.
package bsd_pkg;

    typedef struct packed {
        logic neg;
        logic pos;
    } sdig_t;

    // Integer value of one digit; assumes the pair is never (1,1).
    function automatic int sdig_val(sdig_t d);
        return (d.pos ? 1 : 0) - (d.neg ? 1 : 0);
    endfunction

endpackage

// File: rtl/bsd_negate.sv
// Conditional negation of a signed-digit vector.
// A digit is negated by exchanging its neg and pos flags, so no arithmetic is needed.
// Assumes legal digits at the input; legality is preserved.
module bsd_negate #(
    parameter int NDIG = 8
) (
    input  logic            en_i,
    input  logic [NDIG-1:0] in_neg_i,
    input  logic [NDIG-1:0] in_pos_i,
    output logic [NDIG-1:0] out_neg_o,
    output logic [NDIG-1:0] out_pos_o
);

    // Swap the flag vectors when negation is requested.
    always_comb begin
        out_neg_o = en_i ? in_pos_i : in_neg_i;
        out_pos_o = en_i ? in_neg_i : in_pos_i;
    end

endmodule

// File: rtl/bsd_digit_cell.sv
// One position of the carry-free adder.
// Inputs: operand digits x and y, the transfer and hint from the lower neighbour.
// Outputs: transfer and hint for the upper neighbour, and the sum digit.
// Assumes the incoming pair obeys: transfer +1 -> hint 0, transfer -1 -> hint 1.
// The outgoing transfer never looks at the incoming transfer, so nothing ripples.
module bsd_digit_cell
    import bsd_pkg::*;
(
    input  sdig_t x_i,
    input  sdig_t y_i,
    input  sdig_t t_i,
    input  logic  h_i,
    output sdig_t t_o,
    output logic  h_o,
    output sdig_t s_o
);

    logic x_zero, y_zero;
    logic amb_neg, amb_pos, amb;
    logic lift, drop;

    // Detect the ambiguous operand pairs: one digit zero, the other nonzero.
    always_comb begin
        x_zero  = !x_i.neg && !x_i.pos;
        y_zero  = !y_i.neg && !y_i.pos;
        amb_neg = (x_zero && y_i.neg) || (y_zero && x_i.neg);
        amb_pos = (x_zero && y_i.pos) || (y_zero && x_i.pos);
        amb     = amb_neg || amb_pos;
    end

    // Hint for the neighbour: set when either operand digit is -1.
    always_comb h_o = x_i.neg || y_i.neg;

    // Transfer digit: forced by matching operands, or chosen by the hint when ambiguous.
    always_comb begin
        t_o.neg = (x_i.neg && y_i.neg) || (h_i && amb_neg);
        t_o.pos = (x_i.pos && y_i.pos) || (!h_i && amb_pos);
    end

    // Sum digit: incoming transfer shifted by the ambiguous interim digit (+1 when lift, -1 when drop).
    always_comb begin
        lift    = amb && h_i;
        drop    = amb && !h_i;
        s_o.neg = (t_i.neg && !lift) || (drop && !t_i.pos);
        s_o.pos = (t_i.pos && !drop) || (lift && !t_i.neg);
    end

endmodule

// File: rtl/bsd_cf_adder.sv
// Carry-free adder/subtractor for binary signed-digit numbers.
// Operands are NDIG digits as neg/pos flag vectors; the result has NDIG+1 digits
// and is registered once. The lowest position sees zero transfer and zero hint.
// Assumes operand digits are never (1,1).
module bsd_cf_adder
    import bsd_pkg::*;
#(
    parameter int NDIG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sub_i,
    input  logic [NDIG-1:0] a_neg_i,
    input  logic [NDIG-1:0] a_pos_i,
    input  logic [NDIG-1:0] b_neg_i,
    input  logic [NDIG-1:0] b_pos_i,
    output logic [NDIG:0]   sum_neg_o,
    output logic [NDIG:0]   sum_pos_o
);

    localparam int NOUT = NDIG + 1;

    logic [NDIG-1:0] yb_neg, yb_pos;
    sdig_t           xd [NDIG];
    sdig_t           yd [NDIG];
    sdig_t           sd [NDIG];
    sdig_t           tr [NOUT];
    logic            hn [NOUT];
    logic [NOUT-1:0] nxt_neg, nxt_pos;

    bsd_negate #(.NDIG(NDIG)) u_neg (
        .en_i      (sub_i),
        .in_neg_i  (b_neg_i),
        .in_pos_i  (b_pos_i),
        .out_neg_o (yb_neg),
        .out_pos_o (yb_pos)
    );

    // Position 0 has no lower neighbour.
    assign tr[0] = '0;
    assign hn[0] = 1'b0;

    for (genvar g = 0; g < NDIG; g++) begin : g_pos
        assign xd[g] = {a_neg_i[g], a_pos_i[g]};
        assign yd[g] = {yb_neg[g], yb_pos[g]};

        bsd_digit_cell u_cell (
            .x_i (xd[g]),
            .y_i (yd[g]),
            .t_i (tr[g]),
            .h_i (hn[g]),
            .t_o (tr[g+1]),
            .h_o (hn[g+1]),
            .s_o (sd[g])
        );

        // R5
        digit_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sdig_val(xd[g]) + sdig_val(yd[g]) + sdig_val(tr[g])
                == 2 * sdig_val(tr[g+1]) + sdig_val(sd[g]));

        // R6
        hint_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tr[g+1].pos |-> !hn[g+1]);

        // R6
        hint_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tr[g+1].neg |-> hn[g+1]);
    end

    // Gather sum digits and the final transfer into flag vectors.
    always_comb begin
        for (int k = 0; k < NDIG; k++) begin
            nxt_neg[k] = sd[k].neg;
            nxt_pos[k] = sd[k].pos;
        end
        nxt_neg[NDIG] = tr[NDIG].neg;
        nxt_pos[NDIG] = tr[NDIG].pos;
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_neg_o <= '0;
            sum_pos_o <= '0;
        end else begin
            sum_neg_o <= nxt_neg;
            sum_pos_o <= nxt_pos;
        end
    end

    // R1
    legal_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sum_neg_o & sum_pos_o) == 0);

endmodule

// File: tb/bsd_cf_adder_bench.sv
`timescale 1ns/1ps
module bsd_cf_adder_bench;

    localparam int NS = 4;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          s_sub = 1'b0, b_sub = 1'b0;
    logic [NS-1:0] s_an = '0, s_ap = '0, s_bn = '0, s_bp = '0;
    logic [NB-1:0] b_an = '0, b_ap = '0, b_bn = '0, b_bp = '0;
    logic [NS:0]   s_on, s_op;
    logic [NB:0]   b_on, b_op;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int exp_q[$];

    bsd_cf_adder #(.NDIG(NS)) u_bsd_cf_adder_small (
        .clk(clk), .rst_n(rst_n), .sub_i(s_sub),
        .a_neg_i(s_an), .a_pos_i(s_ap), .b_neg_i(s_bn), .b_pos_i(s_bp),
        .sum_neg_o(s_on), .sum_pos_o(s_op));

    bsd_cf_adder #(.NDIG(NB)) u_bsd_cf_adder (
        .clk(clk), .rst_n(rst_n), .sub_i(b_sub),
        .a_neg_i(b_an), .a_pos_i(b_ap), .b_neg_i(b_bn), .b_pos_i(b_bp),
        .sum_neg_o(b_on), .sum_pos_o(b_op));

    // Reference value of a digit vector, from the coding in R1.
    function automatic int vec_val(logic [31:0] n, logic [31:0] p, int w);
        int v = 0;
        for (int k = 0; k < w; k++) v += ((p[k] ? 1 : 0) - (n[k] ? 1 : 0)) * (1 << k);
        return v;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Random legal digit into position k of a pair of vectors.
    task automatic rnd_vec(output logic [NB-1:0] n, output logic [NB-1:0] p);
        for (int k = 0; k < NB; k++) begin
            int d = int'($urandom_range(0, 2)) - 1;
            n[k] = (d < 0);
            p[k] = (d > 0);
        end
    endtask

    // Apply to the wide instance, wait one edge, check value and legality (R2/R3/R1).
    task automatic run_big(logic [NB-1:0] an, ap, bn, bp, logic sub);
        int e, act;
        b_an = an; b_ap = ap; b_bn = bn; b_bp = bp; b_sub = sub;
        exp_q.push_back(sub ? vec_val(an, ap, NB) - vec_val(bn, bp, NB)
                            : vec_val(an, ap, NB) + vec_val(bn, bp, NB));
        @(negedge clk);
        e = exp_q.pop_front();
        act = vec_val(b_on, b_op, NB + 1);
        chk(act == e, sub ? "R3 wide" : "R2 wide", act, e);
        chk((b_on & b_op) == '0, "R1 wide legal", int'(b_on & b_op), 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] an, ap, bn, bp, rn, rp;
        // R7: reset clears the output even with nonzero operands applied
        b_ap = '1; b_bp = '1; s_ap = '1; s_bp = '1;
        @(negedge clk); @(negedge clk);
        chk(b_on == '0 && b_op == '0, "R7 reset wide", int'(b_op), 0);
        chk(s_on == '0 && s_op == '0, "R7 reset small", int'(s_op), 0);
        rst_n = 1'b1;

        // R4: all +1 plus all +1, top digit is the final transfer of +1
        run_big('0, '1, '0, '1, 1'b0);
        chk(b_op[NB] && !b_on[NB], "R4 top digit", int'({b_on[NB], b_op[NB]}), 1);

        // R2/R3/R5/R6: exhaustive sweep on the four-digit instance
        for (int code = 0; code < 6561; code++) begin
            for (int sb = 0; sb < 2; sb++) begin
                int c = code;
                int e, act;
                for (int k = 0; k < 2 * NS; k++) begin
                    int d = (c % 3) - 1;
                    c = c / 3;
                    if (k < NS) begin s_an[k] = (d < 0); s_ap[k] = (d > 0); end
                    else begin s_bn[k-NS] = (d < 0); s_bp[k-NS] = (d > 0); end
                end
                s_sub = sb[0];
                exp_q.push_back(sb != 0 ? vec_val(s_an, s_ap, NS) - vec_val(s_bn, s_bp, NS)
                                        : vec_val(s_an, s_ap, NS) + vec_val(s_bn, s_bp, NS));
                @(negedge clk);
                e = exp_q.pop_front();
                act = vec_val(s_on, s_op, NS + 1);
                chk(act == e, sb != 0 ? "R3 exhaustive" : "R2 exhaustive", act, e);
                chk((s_on & s_op) == '0, "R1 exhaustive legal", int'(s_on & s_op), 0);
            end
        end

        // R2/R3: random vectors on the eight-digit instance
        for (int r = 0; r < 1500; r++) begin
            rnd_vec(an, ap); rnd_vec(bn, bp);
            run_big(an, ap, bn, bp, r[0]);
        end

        // R9: self-subtraction gives all-zero digits
        for (int r = 0; r < 50; r++) begin
            rnd_vec(an, ap);
            run_big(an, ap, an, ap, 1'b1);
            chk(b_on == '0 && b_op == '0, "R9 self subtract", int'(b_op | b_on), 0);
        end

        // R8: a change at position j reaches only result digits j..j+2
        for (int j = 0; j < NB; j++) begin
            for (int r = 0; r < 20; r++) begin
                logic [NB:0] mask;
                rnd_vec(an, ap); rnd_vec(bn, bp);
                run_big(an, ap, bn, bp, r[1]);
                rn = b_on[NB-1:0]; rp = b_op[NB-1:0];
                begin
                    logic [NB:0] on0, op0;
                    on0 = b_on; op0 = b_op;
                    if (ap[j]) begin ap[j] = 1'b0; an[j] = r[0]; end
                    else if (an[j]) begin an[j] = 1'b0; ap[j] = r[0]; end
                    else begin ap[j] = r[0]; an[j] = !r[0]; end
                    run_big(an, ap, bn, bp, r[1]);
                    mask = '1;
                    for (int k = j; k <= j + 2 && k <= NB; k++) mask[k] = 1'b0;
                    chk(((b_on ^ on0) & mask) == '0 && ((b_op ^ op0) & mask) == '0,
                        "R8 locality", int'(((b_on ^ on0) | (b_op ^ op0)) & mask), 0);
                end
            end
        end

        // R7: mid-run reset clears, then latency of one edge resumes
        rst_n = 1'b0;
        b_ap = '1; b_an = '0;
        @(negedge clk);
        chk(b_on == '0 && b_op == '0, "R7 mid reset", int'(b_op), 0);
        rst_n = 1'b1;
        run_big('0, 8'h01, '0, 8'h01, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule